// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle-Frame Generation

This block turns bytes written by a host into an asynchronous serial bit stream. A single holding register feeds a shift register. One bit goes out per baud tick, which arrives from a baud generator outside the block. Each frame is built from three settings: the data width (8 or 9 bits), parity on or off, and even or odd parity. The host learns the block's state from two flags. The empty flag reports that the holding register can take a new character. The complete flag reports that the line has gone quiet.

Writes to the holding register follow an acknowledge rule. The host must first read status while the empty flag is set, and only the write that follows that read is taken for transmission. A write made while a byte is still waiting replaces that byte.

Two extra kinds of frame can be queued next to data frames. A break request makes the line go low for whole frame lengths. These frames start only after the frame in progress has finished, and they repeat for as long as the request is held. An idle request queues one frame of all ones. When several kinds of frame are waiting at a frame boundary, break goes first, then the idle frame, then data.

Top module: `serial_tx_break`

## Requirements
- R1: While `rst` is asserted and after it is released, `txd` is 1, `tdre` is 1 and `tc` is 1.
- R2: A data frame is sent least significant bit first, in this order: start bit 0, then 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1), then a parity bit if `par_en`=1, then one stop bit of 1. Each bit lasts exactly one baud tick interval, and `txd` changes only at a clock edge where `baud_tick` is 1.
- R3: The parity bit makes the total count of ones in the data bits plus the parity bit even when `par_odd`=0, and odd when `par_odd`=1.
- R4: `tdre` rises at the same edge where the held byte moves into the shifter. At that edge the start bit appears on `txd`.
- R5: A write clears `tdre` and is queued for sending only if it comes after a `stat_rd` pulse that was made while `tdre` was 1. A write without that pulse, or after a pulse made while `tdre` was 0, leaves `tdre` at 1 and sends nothing.
- R6: A write while `tdre` is 0 replaces the waiting byte, and the earlier byte is never sent. A write in the same cycle as the tick that moves the byte into the shifter is dropped.
- R7: A data byte waiting when a stop bit ends starts its start bit in the very next bit interval, with no idle bit between the two frames.
- R8: `tc` drops in the cycle after a request is accepted (a write, `idle_req` or `brk_req`). It rises only at the tick that ends the last queued frame of any kind. While `tc` is 1, `txd` is 1.
- R9: If `brk_req` is raised while a frame is being sent, that frame finishes unchanged. After it, all-zero frames follow, each as long as a data frame, until `brk_req` falls.
- R10: A `brk_req` pulse shorter than one frame produces one break frame, or two if the pulse is high across a frame boundary. After that the line returns to idle, or goes on with queued data.
- R11: An `idle_req` pulse queues one frame of all ones, as long as a data frame. `tc` stays 0 until that frame ends.
- R12: A data byte written while break frames are being sent stays waiting, with `tdre` at 0. It goes out directly after the last break frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit interval |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Adds a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| stat_rd | input | 1 | Host status read; arms the next write when tdre is 1 |
| wr_en | input | 1 | Host write strobe to the holding register |
| wr_data | input | DATA_W | Character to send |
| brk_req | input | 1 | Level request for break frames |
| idle_req | input | 1 | Pulse that queues one all-ones frame |
| txd | output | 1 | Serial line, idles high |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmitter complete and line idle |

## Verification
The case that needs care is a host write landing in the same cycle as the baud tick that moves the waiting byte into the shifter. The bench lines up a write with the exact edge where the tick is high. The byte that was already waiting must go out alone, the new byte must never appear, and `tdre` must end at 1. A second case is a break pulse held across a frame boundary. Break selection and break latching then happen on the same edge, and the bench expects exactly two frames of low line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    FR_NONE  = 2'd0,
    FR_DATA  = 2'd1,
    FR_IDLE  = 2'd2,
    FR_BREAK = 2'd3
  } frame_kind_t;
endpackage

// File: rtl/sertx_hold.sv
// Holding register with the status-read-then-write acceptance rule.
module sertx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_valid,
  output logic              wr_acc
);
  logic armed;

  // a write is taken for sending only when empty and armed by a status read
  assign wr_acc = wr_en & ~hold_valid & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data  <= '0;
      hold_valid <= 1'b0;
      armed      <= 1'b0;
    end else begin
      // overwrite while full; a write coincident with load is lost with the valid bit
      if (wr_en && (hold_valid || armed)) hold_data <= wr_data;
      if (load)        hold_valid <= 1'b0;
      else if (wr_acc) hold_valid <= 1'b1;
      if (wr_en)                       armed <= 1'b0;
      else if (stat_rd && !hold_valid) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_frame.sv
// Builds the bit vector and length of the next frame (combinational).
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               nine_bit,
  input  logic               par_en,
  input  logic               par_odd,
  input  frame_kind_t        kind,
  output logic [FRAME_W-1:0] vec,
  output logic [CNT_W-1:0]   len
);
  localparam int SHORT_W = DATA_W - 1;

  logic [DATA_W-1:0]  used_bits;
  logic               par_bit;
  logic [FRAME_W-1:0] dvec;
  int                 ppos;

  always_comb begin
    used_bits = nine_bit ? data : {1'b0, data[DATA_W-2:0]};
    par_bit   = (^used_bits) ^ par_odd;
    dvec      = '1;
    dvec[0]   = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (nine_bit || i < SHORT_W) dvec[1+i] = data[i];
    end
    ppos = nine_bit ? DATA_W + 1 : DATA_W;
    if (par_en) dvec[ppos] = par_bit;
    len = CNT_W'(nine_bit ? DATA_W + 2 : DATA_W + 1) + CNT_W'(par_en);
    case (kind)
      FR_BREAK: vec = '0;
      FR_IDLE:  vec = '1;
      default:  vec = dvec;
    endcase
  end
endmodule

// File: rtl/sertx_seq.sv
// Frame sequencer: picks break/idle/data at boundaries and shifts bits out.
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baud_tick,
  input  logic               hold_valid,
  input  logic               wr_acc,
  input  logic               brk_req,
  input  logic               idle_req,
  input  logic [FRAME_W-1:0] vec,
  input  logic [CNT_W-1:0]   len,
  output frame_kind_t        kind,
  output logic               load,
  output logic               txd,
  output logic               tc
);
  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic               brk_seen;
  logic               pre_pend;
  logic               boundary;
  logic               start;

  always_comb begin
    if (brk_req || brk_seen) kind = FR_BREAK;
    else if (pre_pend)       kind = FR_IDLE;
    else if (hold_valid)     kind = FR_DATA;
    else                     kind = FR_NONE;
  end

  assign boundary = baud_tick & (~busy | (cnt == '0));
  assign start    = boundary & (kind != FR_NONE);
  assign load     = start & (kind == FR_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      sh       <= '1;
      txd      <= 1'b1;
      tc       <= 1'b1;
      brk_seen <= 1'b0;
      pre_pend <= 1'b0;
    end else begin
      brk_seen <= brk_req | (brk_seen & ~(start & (kind == FR_BREAK)));
      pre_pend <= idle_req | (pre_pend & ~(start & (kind == FR_IDLE)));
      if (boundary) begin
        if (start) begin
          txd  <= vec[0];
          sh   <= {1'b1, vec[FRAME_W-1:1]};
          cnt  <= len - CNT_W'(1);
          busy <= 1'b1;
        end else begin
          txd  <= 1'b1;
          busy <= 1'b0;
        end
      end else if (baud_tick && busy) begin
        txd <= sh[0];
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        cnt <= cnt - CNT_W'(1);
      end
      if (wr_acc || idle_req || brk_req)  tc <= 1'b0;
      else if (boundary && !start && busy) tc <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx_break.sv
module serial_tx_break
  import sertx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stat_rd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_req,
  input  logic              idle_req,
  output logic              txd,
  output logic              tdre,
  output logic              tc
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_data;
  logic               hold_valid;
  logic               wr_acc;
  logic               load;
  frame_kind_t        kind;
  logic [FRAME_W-1:0] vec;
  logic [CNT_W-1:0]   len;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .wr_en(wr_en), .wr_data(wr_data),
    .load(load), .hold_data(hold_data), .hold_valid(hold_valid), .wr_acc(wr_acc)
  );

  sertx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .data(hold_data), .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .kind(kind), .vec(vec), .len(len)
  );

  sertx_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .hold_valid(hold_valid),
    .wr_acc(wr_acc), .brk_req(brk_req), .idle_req(idle_req), .vec(vec), .len(len),
    .kind(kind), .load(load), .txd(txd), .tc(tc)
  );

  assign tdre = ~hold_valid;
endmodule

// File: rtl/serial_tx_break_chk.sv
module serial_tx_break_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic wr_en,
  input logic brk_req,
  input logic idle_req,
  input logic txd,
  input logic tdre,
  input logic tc
);
  AST_TC_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tc |-> txd); // R8
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(txd)); // R2
  AST_EMPTY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(tdre) |-> $past(baud_tick)); // R4
  AST_EMPTY_WITH_START: assert property (@(posedge clk) disable iff (rst)
    $rose(tdre) |-> !txd); // R4
  AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(tdre) |-> $past(wr_en)); // R5
  AST_TC_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(tc) |-> $past(wr_en || idle_req || brk_req)); // R8
endmodule

bind serial_tx_break serial_tx_break_chk u_chk (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .brk_req(brk_req),
  .idle_req(idle_req), .txd(txd), .tdre(tdre), .tc(tc)
);

// File: tb/serial_tx_break_tb.sv
`timescale 1ns/100ps
module serial_tx_break_tb;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst, baud_tick, nine_bit, par_en, par_odd, stat_rd, wr_en, brk_req, idle_req;
  logic [8:0] wr_data;
  logic txd, tdre, tc;

  int nchk = 0, nfail = 0;
  logic logv [0:4095];
  int lcnt = 0, tcyc = 0, tc_rise_idx = -1;
  logic tc_q = 1'b1;

  always #2 clk = ~clk;

  serial_tx_break #(.DATA_W(9)) u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .nine_bit(nine_bit), .par_en(par_en),
    .par_odd(par_odd), .stat_rd(stat_rd), .wr_en(wr_en), .wr_data(wr_data),
    .brk_req(brk_req), .idle_req(idle_req), .txd(txd), .tdre(tdre), .tc(tc)
  );

  // tick source and line log: one entry per bit interval
  initial begin
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (baud_tick && lcnt < 4096) begin logv[lcnt] = txd; lcnt++; end
      if (tc === 1'b1 && tc_q === 1'b0) tc_rise_idx = lcnt - 1;
      tc_q = tc;
      tcyc++;
      baud_tick = (tcyc % DIV == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int flen();
    return 2 + (nine_bit ? 9 : 8) + (par_en ? 1 : 0);
  endfunction

  function automatic logic [11:0] exp_vec(input logic [8:0] d);
    logic [11:0] v = '1;
    logic p = par_odd;
    int nb = nine_bit ? 9 : 8;
    v[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin v[1+i] = d[i]; p = p ^ d[i]; end
    if (par_en) v[1+nb] = p;
    return v;
  endfunction

  function automatic int first_zero(input int s);
    for (int i = s; i < lcnt; i++) if (logv[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic int zero_run(input int s);
    int n = 0;
    for (int i = s; i < lcnt && logv[i] == 1'b0; i++) n++;
    return n;
  endfunction

  function automatic bit ones_after(input int s);
    for (int i = s; i < lcnt; i++) if (logv[i] == 1'b0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_frame(input int at, input logic [8:0] d, input string req);
    logic [11:0] ev = exp_vec(d);
    int act = 0, exp = 0;
    for (int i = 0; i < flen(); i++) begin
      act = act | (((at >= 0 && at + i < lcnt) ? int'(logv[at+i]) : 1) << i);
      exp = exp | (int'(ev[i]) << i);
    end
    chk(at >= 0 && act == exp, req, "frame bits", act, exp);
  endtask

  task automatic align();
    do begin @(negedge clk); #1; end while (!baud_tick);
  endtask

  task automatic send_byte(input logic [8:0] d);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (tc !== 1'b1 && n < 8000) begin @(negedge clk); n++; end
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic wait_empty();
    int n = 0;
    while (tdre !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int s, f, z, L;
    rst = 1'b1; nine_bit = 0; par_en = 0; par_odd = 0;
    stat_rd = 0; wr_en = 0; wr_data = '0; brk_req = 0; idle_req = 0;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1 && tdre === 1'b1 && tc === 1'b1, "R1", "flags in reset", {txd, tdre, tc}, 7);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && tdre === 1'b1 && tc === 1'b1, "R1", "flags after reset", {txd, tdre, tc}, 7);
    L = flen();

    // R4 and R8 timing on a single byte
    align(); s = lcnt;
    send_byte(9'h05A);
    chk(tdre === 1'b0, "R5", "tdre after acked write", tdre, 0);
    chk(tc === 1'b0, "R8", "tc after write", tc, 0);
    wait_empty();
    chk(txd === 1'b0 && tc === 1'b0, "R4", "start bit with tdre rise", {txd, tc}, 0);
    wait_idle();
    f = first_zero(s);
    check_frame(f, 9'h05A, "R2");
    chk(tc_rise_idx == f + L, "R8", "tc rise tick", tc_rise_idx, f + L);

    // R2 R3 sweep over all format settings
    for (int cfg = 0; cfg < 8; cfg++) begin
      nine_bit = cfg[0]; par_en = cfg[1]; par_odd = cfg[2];
      for (int k = 0; k < 4; k++) begin
        logic [8:0] d = 9'((cfg * 53 + k * 97 + 11) & 511);
        s = lcnt;
        send_byte(d);
        wait_idle();
        f = first_zero(s);
        check_frame(f, d, "R2 R3 sweep");
      end
    end
    nine_bit = 0; par_en = 0; par_odd = 0; L = flen();

    // R5 write without a status read
    s = lcnt;
    @(negedge clk); wr_en = 1'b1; wr_data = 9'h033;
    @(negedge clk); wr_en = 1'b0;
    repeat (200) @(negedge clk);
    chk(tdre === 1'b1 && tc === 1'b1, "R5", "flags after unacked write", {tdre, tc}, 3);
    chk(first_zero(s) == -1, "R5", "line stayed idle", first_zero(s), -1);

    // R5 status read while full does not arm
    align(); s = lcnt;
    send_byte(9'h00F);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    wait_empty();
    @(negedge clk); wr_en = 1'b1; wr_data = 9'h0F0;
    @(negedge clk); wr_en = 1'b0;
    wait_idle();
    f = first_zero(s);
    check_frame(f, 9'h00F, "R5");
    chk(ones_after(f + L), "R5", "no frame for unarmed write", 0, 1);

    // R6 overwrite while full
    align(); s = lcnt;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; wr_en = 1'b1; wr_data = 9'h081;
    @(negedge clk); wr_data = 9'h03C;
    @(negedge clk); wr_en = 1'b0;
    wait_idle();
    f = first_zero(s);
    check_frame(f, 9'h03C, "R6");
    chk(ones_after(f + L), "R6", "overwritten byte not sent", 0, 1);

    // R6 write coincident with the transfer tick
    align(); s = lcnt;
    send_byte(9'h096);
    do begin @(negedge clk); #1; end while (!baud_tick);
    wr_en = 1'b1; wr_data = 9'h069;
    @(negedge clk); wr_en = 1'b0;
    wait_idle();
    f = first_zero(s);
    check_frame(f, 9'h096, "R6");
    chk(ones_after(f + L) && tdre === 1'b1, "R6", "coincident write dropped", tdre, 1);

    // R7 back to back frames
    align(); s = lcnt;
    send_byte(9'h011);
    wait_empty();
    send_byte(9'h022);
    wait_idle();
    f = first_zero(s);
    check_frame(f, 9'h011, "R7");
    check_frame(f + L, 9'h022, "R7");
    chk(tc_rise_idx == f + 2 * L, "R8", "tc rise after second frame", tc_rise_idx, f + 2 * L);

    // R11 idle frame
    align(); s = lcnt;
    @(negedge clk); idle_req = 1'b1;
    @(negedge clk); idle_req = 1'b0;
    chk(tc === 1'b0, "R11", "tc low after idle request", tc, 0);
    wait_idle();
    chk(first_zero(s) == -1, "R11", "idle frame all ones", first_zero(s), -1);
    chk(tc_rise_idx == s + 1 + L, "R11", "tc rise after idle frame", tc_rise_idx, s + 1 + L);

    // R9 break raised during a frame
    align(); s = lcnt;
    send_byte(9'h0FF);
    repeat (24) @(negedge clk); brk_req = 1'b1;
    repeat (300) @(negedge clk); brk_req = 1'b0;
    wait_idle();
    f = first_zero(s);
    check_frame(f, 9'h0FF, "R9");
    z = zero_run(f + L);
    chk(z % L == 0 && z >= 2 * L, "R9", "break run length", z, 2 * L);
    chk(ones_after(f + L + z), "R9", "idle after break", 0, 1);

    // R10 short pulse while idle: one break frame
    align(); s = lcnt;
    @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    wait_idle();
    f = first_zero(s);
    chk(zero_run(f) == L, "R10", "single break frame", zero_run(f), L);

    // R10 pulse across a frame boundary: two break frames
    align(); s = lcnt;
    brk_req = 1'b1;
    @(negedge clk);
    @(negedge clk); brk_req = 1'b0;
    wait_idle();
    f = first_zero(s);
    chk(zero_run(f) == 2 * L, "R10", "double break frame", zero_run(f), 2 * L);

    // R10 short pulse during a frame
    align(); s = lcnt;
    send_byte(9'h0FF);
    repeat (20) @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    wait_idle();
    f = first_zero(s);
    chk(zero_run(f + L) == L, "R10", "one break after frame", zero_run(f + L), L);

    // R12 data queued behind break frames
    align(); s = lcnt;
    brk_req = 1'b1;
    repeat (4) @(negedge clk);
    send_byte(9'h05B);
    repeat (150) @(negedge clk);
    chk(tdre === 1'b0, "R12", "byte waits during break", tdre, 0);
    brk_req = 1'b0;
    wait_idle();
    f = first_zero(s);
    z = zero_run(f);
    chk((z - 1) % L == 0 && z > L, "R12", "break run before data", z, 2 * L + 1);
    check_frame(f + z - 1, 9'h05B, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule